// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block supplies the word address for a four-beat burst into a synchronous memory array. When a burst begins, the caller pulses a load strobe together with a full external address. The block captures that address and presents it as the first beat. On each later clock edge where the active-low advance input is low, it steps to the next beat. Only the two lowest address bits change. The upper bits stay at the captured value until the next load.

A static order-select pin picks how the low two bits are sequenced. Linear order counts them upward modulo four from the captured start value. Interleaved order forms them as the start value XOR a beat count that runs 0, 1, 2, 3. Either order wraps to the first beat after the fourth. The select pin is not registered, so a change on it is visible on the output without waiting for a clock edge. Advance held high suspends the burst on the current address. A load strobe always wins: it restarts the burst from the new external address, even in the middle of a burst.

Top module: `burst_seq_addr`

## Requirements
- R1: While synchronous reset `rst` is high at a rising clock edge, the address register and beat count clear, so `addr_o` reads all zeros after that edge.
- R2: When `load_i` is high at a rising edge, `addr_o` equals the `ext_addr_i` value sampled at that edge, on every bit, until the next edge.
- R3: At an edge without `load_i`, bits `addr_o[AW-1:2]` keep their previous value.
- R4: With `order_sel_i` = 0 (linear), each edge that has `load_i` low and `adv_n_i` low changes `addr_o[1:0]` to its previous value plus one, modulo 4. For example, start 01 gives 01, 10, 11, 00.
- R5: With `order_sel_i` = 1 (interleaved), `addr_o[1:0]` equals the captured start bits XOR the number of advances since the load, modulo 4. For example, start 01 gives 01, 00, 11, 10, and start 11 gives 11, 10, 01, 00.
- R6: An edge with `load_i` low and `adv_n_i` high leaves `addr_o` unchanged, as long as `order_sel_i` does not change.
- R7: After four advances, in either order, `addr_o` returns to the address captured at the load, and the sequence repeats if advancing continues.
- R8: `load_i` has priority over `adv_n_i`. A load at any beat restarts the burst from the new external address, and the beat count returns to zero.
- R9: `order_sel_i` acts combinationally. A change on it between clock edges immediately remaps `addr_o[1:0]` for the current beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Start a burst from `ext_addr_i` |
| ext_addr_i | input | AW | External start address |
| adv_n_i | input | 1 | Advance to next beat when low |
| order_sel_i | input | 1 | 0 selects linear order, 1 selects interleaved order |
| addr_o | output | AW | Current array word address |

## Verification
The bench goes after these corner cases:
- Start values 01 and 11. Here the linear and interleaved sequences differ on the second beat, so a design that adds where it should XOR (or the reverse) shows a wrong second address.
- Wrap after the fourth beat. An off-by-one wrap, or a carry leaking into bit 2, breaks the return to the start address and disturbs the upper bits.
- A reload asserted together with advance, in mid-burst. A design that gives advance priority, or that forgets to clear the beat count, lands one beat off.
- Flipping the order pin between edges. This exposes a design that registers the pin.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    localparam int unsigned LOW_W = 2;

    typedef logic [LOW_W-1:0] low_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } cmd_e;

    // Load beats advance; advance is active low.
    function automatic cmd_e decode_cmd(input logic load, input logic adv_n);
        if (load)
            return CMD_LOAD;
        else if (!adv_n)
            return CMD_STEP;
        else
            return CMD_HOLD;
    endfunction

    function automatic low_t low_linear(input low_t start, input low_t beat);
        return low_t'(start + beat);
    endfunction

    function automatic low_t low_interleave(input low_t start, input low_t beat);
        return start ^ beat;
    endfunction

endpackage

// File: rtl/bseq_capture.sv
module bseq_capture
    import bseq_pkg::*;
#(
    parameter int unsigned AW = 16,
    localparam int unsigned UW = AW - LOW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  cmd_e          cmd_i,
    input  logic [AW-1:0] ext_addr_i,
    output logic [UW-1:0] upper_o,
    output low_t          start_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_o <= '0;
            start_o <= '0;
        end else if (cmd_i == CMD_LOAD) begin
            upper_o <= ext_addr_i[AW-1:LOW_W];
            start_o <= ext_addr_i[LOW_W-1:0];
        end
    end

    p_upper_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_i != CMD_LOAD) |=> $stable(upper_o));

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
    import bseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_i,
    output low_t beat_o
);

    always_ff @(posedge clk) begin
        if (rst)
            beat_o <= '0;
        else begin
            unique case (cmd_i)
                CMD_LOAD: beat_o <= '0;
                CMD_STEP: beat_o <= low_t'(beat_o + 1'b1);
                default:  beat_o <= beat_o;
            endcase
        end
    end

    p_beat_step_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_STEP) |=> (beat_o == low_t'($past(beat_o) + 1'b1)));

    p_beat_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_i == CMD_LOAD) |=> (beat_o == '0));

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import bseq_pkg::*;
(
    input  order_e order_i,
    input  low_t   start_i,
    input  low_t   beat_i,
    output low_t   low_o
);

    low_t lin_w;
    low_t ilv_w;

    assign lin_w = low_linear(start_i, beat_i);
    assign ilv_w = low_interleave(start_i, beat_i);

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: low_o = ilv_w;
            default:        low_o = lin_w;
        endcase
    end

endmodule

// File: rtl/burst_seq_addr.sv
module burst_seq_addr
    import bseq_pkg::*;
#(
    parameter int unsigned AW = 16,
    localparam int unsigned UW = AW - LOW_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] ext_addr_i,
    input  logic          adv_n_i,
    input  logic          order_sel_i,
    output logic [AW-1:0] addr_o
);

    cmd_e          cmd_w;
    order_e        order_w;
    logic [UW-1:0] upper_w;
    low_t          start_w;
    low_t          beat_w;
    low_t          low_w;

    assign cmd_w   = decode_cmd(load_i, adv_n_i);
    assign order_w = order_e'(order_sel_i);

    bseq_capture #(.AW(AW)) u_capture (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd_w),
        .ext_addr_i (ext_addr_i),
        .upper_o    (upper_w),
        .start_o    (start_w)
    );

    bseq_beat_ctr u_beat (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd_w),
        .beat_o (beat_w)
    );

    bseq_order_map u_map (
        .order_i (order_w),
        .start_i (start_w),
        .beat_i  (beat_w),
        .low_o   (low_w)
    );

    assign addr_o = {upper_w, low_w};

    p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (addr_o == $past(ext_addr_i)));

    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!load_i && adv_n_i) |=>
            ((addr_o == $past(addr_o)) || (order_sel_i != $past(order_sel_i))));

endmodule

// File: tb/test_burst_seq_addr.sv
module test_burst_seq_addr;

    localparam int  AW      = 16;
    localparam time CLK_PER = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_i = 1'b0;
    logic [AW-1:0] ext_addr_i = '0;
    logic          adv_n_i = 1'b1;
    logic          order_sel_i = 1'b0;
    logic [AW-1:0] addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int m_base  = 0;
    int m_start = 0;
    int m_adv   = 0;

    always #(CLK_PER/2) clk = ~clk;

    burst_seq_addr #(.AW(AW)) i_burst_seq_addr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .ext_addr_i  (ext_addr_i),
        .adv_n_i     (adv_n_i),
        .order_sel_i (order_sel_i),
        .addr_o      (addr_o)
    );

    function automatic int model_addr(input bit sel);
        int lo;
        if (sel) lo = m_start ^ (m_adv % 4);
        else     lo = (m_start + m_adv) % 4;
        return m_base * 4 + lo;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive, update model at the edge, compare at the falling edge
    task automatic cyc(input string req, input bit ld, input int a, input bit advn);
        load_i     = ld;
        ext_addr_i = AW'(a);
        adv_n_i    = advn;
        @(posedge clk);
        if (rst) begin
            m_base = 0; m_start = 0; m_adv = 0;
        end else if (ld) begin
            m_base = (a % (1 << AW)) / 4; m_start = a % 4; m_adv = 0;
        end else if (!advn) begin
            m_adv = m_adv + 1;
        end
        @(negedge clk);
        check(req, int'(addr_o), model_addr(order_sel_i));
    endtask

    initial begin
        #(CLK_PER * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        repeat (3) cyc("R1", 1'b0, 0, 1'b1);
        check("R1", int'(addr_o), 0);
        rst = 1'b0;

        // R4 linear, start 01, R7 wrap
        order_sel_i = 1'b0;
        cyc("R2", 1'b1, 'hABC1, 1'b1);
        check("R2", int'(addr_o), 'hABC1);
        cyc("R4", 1'b0, 0, 1'b0); check("R4", int'(addr_o[1:0]), 2);
        cyc("R4", 1'b0, 0, 1'b0); check("R4", int'(addr_o[1:0]), 3);
        cyc("R4", 1'b0, 0, 1'b0); check("R4", int'(addr_o[1:0]), 0);
        check("R3", int'(addr_o[AW-1:2]), 'hABC1 >> 2);
        cyc("R7", 1'b0, 0, 1'b0); check("R7", int'(addr_o), 'hABC1);

        // R6 suspend
        cyc("R6", 1'b0, 'h5555, 1'b1); check("R6", int'(addr_o), 'hABC1);
        cyc("R6", 1'b0, 'h5555, 1'b1); check("R6", int'(addr_o), 'hABC1);

        // R5 interleaved, start 11
        order_sel_i = 1'b1;
        cyc("R2", 1'b1, 'h1233, 1'b1);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 2);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 1);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 0);
        cyc("R7", 1'b0, 0, 1'b0); check("R7", int'(addr_o), 'h1233);

        // R5 interleaved, start 01
        cyc("R2", 1'b1, 'hFFFD, 1'b0);
        check("R8", int'(addr_o), 'hFFFD);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 0);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 3);

        // R9 combinational remap: beat 2, start 01 -> linear 11, interleaved 11; use beat 1 instead
        cyc("R8", 1'b1, 'h0401, 1'b0);
        cyc("R4", 1'b0, 0, 1'b0);
        #1 order_sel_i = 1'b0; #1;
        check("R9", int'(addr_o[1:0]), 2);
        order_sel_i = 1'b1; #1;
        check("R9", int'(addr_o[1:0]), 0);

        // R8 mid-burst reload with advance low
        @(negedge clk);
        cyc("R8", 1'b1, 'h7776, 1'b0);
        check("R8", int'(addr_o), 'h7776);
        cyc("R5", 1'b0, 0, 1'b0); check("R5", int'(addr_o[1:0]), 3);

        // mixed stimulus against the model
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            if (i % 50 == 0) order_sel_i = ~order_sel_i;
            cyc((r % 7 == 0) ? "R8" : "R4", (r % 7 == 0), int'($urandom % 65536), r[4] & r[5]);
        end

        // R1 reset mid-burst
        rst = 1'b1;
        cyc("R1", 1'b0, 0, 1'b0);
        check("R1", int'(addr_o), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule